// File: doc/BRIEF.md
# Read/Write Fault Latch and Encoder

This block watches the digital status lines of a disc drive's read/write path: the write, read and erase gates, the sensed erase, AC write and DC write currents, the multi-head detect line and the access-ready line. Seven gate/current combinations are illegal. Each one has its own sticky latch, and once set the latch holds until software-independent hardware pulses the clear input.

Mismatches that involve a sensed current are set only after they have persisted for `SETTLE_CYC` consecutive clock edges. This keeps ordinary current rise and fall after a gate change from being reported. Pure gate conflicts and the head-select fault latch on the first edge. A 3-bit code on three test outputs names the highest-priority latched fault, and a single flag reports whether any latch is set.

Top module: `rw_fault_mon`

## Requirements
- R1: After reset is released, `code_o` is 3'b000 and `fault_o` is 0.
- R2: Each fault maps to a fixed `code_o` value, with bit 2 as the first test point and bit 0 as the last. Erase current without erase gate gives 3'b100. Write gate without erase current gives 3'b010. Read gate with erase gate gives 3'b110. Multi-head detect gives 3'b101. Write gate without AC write current gives 3'b101. DC write current without write gate gives 3'b011. Erase gate without access ready gives 3'b111.
- R3: The four current-sense mismatches are erase current without gate, write without erase current, write without AC current, and DC current without write. Each latches only at the `SETTLE_CYC`-th consecutive clock edge at which it is present. A single edge without the mismatch restarts the count.
- R4: Read-with-erase, multi-head and erase-without-access-ready latch at the first clock edge at which they are present.
- R5: A latched fault stays latched after its condition goes away, until a clear.
- R6: When several faults are latched, `code_o` shows the one listed earliest in R2. Multi-head outranks write-without-AC-current.
- R7: A clock edge with `clr_i` high empties every latch, even if a condition is present at that edge.
- R8: `fault_o` is 1 exactly when at least one latch is set. `code_o` is 3'b000 when none is set.
- R9: A healthy write, with write gate, erase gate, erase current, AC and DC write current and access ready all high, sets no latch however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all fault latches |
| wr_gate_i | input | 1 | Write gate enabled |
| rd_gate_i | input | 1 | Read gate enabled |
| er_gate_i | input | 1 | Erase gate enabled |
| er_cur_i | input | 1 | Erase current sensed |
| ac_wr_i | input | 1 | AC write current (data) sensed |
| dc_wr_i | input | 1 | DC write current sensed |
| multi_head_i | input | 1 | More than one head drive on |
| acc_rdy_i | input | 1 | Access ready |
| code_o | output | 3 | Fault code on the test outputs |
| fault_o | output | 1 | Any fault latched |

## Verification
The bench builds the block with `SETTLE_CYC` = 4. This makes a qualified mismatch latch after four edges, and the bench probes holds of three and four edges to locate the exact latch edge. The short window also lets the bench interrupt a mismatch part-way and confirm that the count restarts. The bench stacks several latched faults in sequence to check the priority order, and it asserts clear together with a live condition.

// File: rtl/rwf_pkg.sv
`timescale 1ns/1ps
package rwf_pkg;
  localparam int NUM_COND = 7;

  // condition index = priority (0 highest)
  typedef enum logic [2:0] {
    C_ERCUR_NOGATE = 3'd0,
    C_WR_NOERASE   = 3'd1,
    C_RD_AND_ER    = 3'd2,
    C_MULTI_HEAD   = 3'd3,
    C_WR_NOAC      = 3'd4,
    C_DC_NOWR      = 3'd5,
    C_ER_NORDY     = 3'd6
  } cond_e;

  // conditions that compare a gate against a sensed current
  localparam logic [NUM_COND-1:0] QUAL_MASK = 7'b011_0011;

  function automatic logic [2:0] code_of(input int idx);
    case (idx)
      0:       return 3'b100;
      1:       return 3'b010;
      2:       return 3'b110;
      3:       return 3'b101;
      4:       return 3'b101;
      5:       return 3'b011;
      6:       return 3'b111;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/rwf_qual.sv
`timescale 1ns/1ps
module rwf_qual #(
  parameter int SETTLE_CYC = 8,
  parameter bit QUAL       = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic hit_o
);
  if (QUAL) begin : g_qual
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (!cond_i)     cnt_q <= '0;
      else if (cnt_q < LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = cond_i && (cnt_q >= LAST);

    AST_QUAL_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST); // R3
    AST_QUAL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cond_i |=> cnt_q == '0); // R3
  end else begin : g_direct
    assign hit_o = cond_i;
  end
endmodule

// File: rtl/rwf_enc.sv
`timescale 1ns/1ps
module rwf_enc
  import rwf_pkg::*;
(
  input  logic [NUM_COND-1:0] lat_i,
  output logic [2:0]          code_o
);
  // scan from lowest priority up so index 0 wins
  always_comb begin
    code_o = 3'b000;
    for (int i = NUM_COND - 1; i >= 0; i--) begin
      if (lat_i[i]) code_o = code_of(i);
    end
  end
endmodule

// File: rtl/rw_fault_mon.sv
`timescale 1ns/1ps
module rw_fault_mon
  import rwf_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_gate_i,
  input  logic       rd_gate_i,
  input  logic       er_gate_i,
  input  logic       er_cur_i,
  input  logic       ac_wr_i,
  input  logic       dc_wr_i,
  input  logic       multi_head_i,
  input  logic       acc_rdy_i,
  output logic [2:0] code_o,
  output logic       fault_o
);
  logic [NUM_COND-1:0] cond, hit, lat_q;

  always_comb begin
    cond                 = '0;
    cond[C_ERCUR_NOGATE] = er_cur_i && !er_gate_i;
    cond[C_WR_NOERASE]   = wr_gate_i && !er_cur_i;
    cond[C_RD_AND_ER]    = rd_gate_i && er_gate_i;
    cond[C_MULTI_HEAD]   = multi_head_i;
    cond[C_WR_NOAC]      = wr_gate_i && !ac_wr_i;
    cond[C_DC_NOWR]      = dc_wr_i && !wr_gate_i;
    cond[C_ER_NORDY]     = er_gate_i && !acc_rdy_i;
  end

  for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
    rwf_qual #(
      .SETTLE_CYC (SETTLE_CYC),
      .QUAL       (QUAL_MASK[g])
    ) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cond_i (cond[g]),
      .hit_o  (hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_q <= '0;
    else if (clr_i) lat_q <= '0;
    else            lat_q <= lat_q | hit;
  end

  rwf_enc u_enc (
    .lat_i  (lat_q),
    .code_o (code_o)
  );

  assign fault_o = |lat_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fault_o && code_o == 3'b000); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !clr_i |=> fault_o); // R5
  AST_FLAG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == (code_o != 3'b000)); // R8
  AST_IMM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gate_i && er_gate_i && !clr_i) |=> fault_o); // R4
  AST_TOP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (er_cur_i && !er_gate_i && fault_o && !clr_i) |=> code_o == 3'b100 || $past(!lat_q[0])); // R6
endmodule

// File: tb/tb_rw_fault_mon.sv
`timescale 1ns/1ps
module tb_rw_fault_mon;
  localparam int SETTLE = 4;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic wr, rd, eg, ec, ac, dc, mh, ar;
  logic [2:0] code;
  logic fault;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rw_fault_mon #(.SETTLE_CYC(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .wr_gate_i(wr), .rd_gate_i(rd), .er_gate_i(eg), .er_cur_i(ec),
    .ac_wr_i(ac), .dc_wr_i(dc), .multi_head_i(mh), .acc_rdy_i(ar),
    .code_o(code), .fault_o(fault)
  );

  // stim = {wr,rd,eg,ec,ac,dc,mh,ar}, hold edges, expected code
  localparam logic [14:0] VEC [NV] = '{
    {8'b0001_0001, 4'd4, 3'b100},  // R2 erase current w/o gate
    {8'b0001_0001, 4'd3, 3'b000},  // R3 one edge short
    {8'b1000_1001, 4'd4, 3'b010},  // R2 write w/o erase current
    {8'b1000_1001, 4'd3, 3'b000},  // R3
    {8'b0111_0001, 4'd1, 3'b110},  // R4 read with erase
    {8'b0000_0011, 4'd1, 3'b101},  // R4 multi head
    {8'b1011_0001, 4'd4, 3'b101},  // R2 write w/o AC current
    {8'b1011_0001, 4'd3, 3'b000},  // R3
    {8'b0000_0101, 4'd4, 3'b011},  // R2 DC w/o write
    {8'b0011_0000, 4'd1, 3'b111},  // R4 erase w/o access ready
    {8'b0001_0101, 4'd4, 3'b100},  // R6 cond0 over DC fault
    {8'b0111_0000, 4'd1, 3'b110},  // R6 read+erase over no-ready
    {8'b1011_1101, 4'd10, 3'b000}  // R9 healthy write
  };

  task automatic set_in(input logic [7:0] s);
    {wr, rd, eg, ec, ac, dc, mh, ar} = s;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [2:0] exp_code);
    checks++;
    if (code !== exp_code || fault !== (exp_code != 3'b000)) begin
      fails++;
      $display("FAIL %s code=%b fault=%b expected code=%b fault=%b",
               req, code, fault, exp_code, exp_code != 3'b000);
    end
  endtask

  task automatic do_clear();
    set_in(8'b0000_0001);
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
  endtask

  initial begin
    set_in(8'b0000_0001);
    #23 rst_n = 1'b1;
    edges(1);
    check("R1", 3'b000);

    for (int i = 0; i < NV; i++) begin
      do_clear();
      set_in(VEC[i][14:7]);
      edges(int'(VEC[i][6:3]));
      check($sformatf("R2/R3/R4/R6/R9 vec%0d", i), VEC[i][2:0]);
    end

    // R5 sticky after condition leaves
    do_clear();
    set_in(8'b0000_0011);
    edges(1);
    set_in(8'b0000_0001);
    edges(5);
    check("R5", 3'b101);

    // R7 clear empties latches
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
    check("R7", 3'b000);

    // R7 clear wins over a live condition, which then re-latches
    set_in(8'b0000_0011);
    clr = 1'b1;
    edges(1);
    clr = 1'b0;
    check("R7 same edge", 3'b000);
    edges(1);
    check("R8 relatch", 3'b101);

    // R3 interrupted mismatch restarts the count
    do_clear();
    set_in(8'b0001_0001);
    edges(3);
    set_in(8'b0000_0001);
    edges(1);
    set_in(8'b0001_0001);
    edges(3);
    check("R3 restart", 3'b000);
    edges(1);
    check("R3 completes", 3'b100);

    // R6 priority over faults latched at different times
    do_clear();
    set_in(8'b0000_0101);
    edges(4);
    set_in(8'b0000_0001);
    edges(1);
    check("R6 dc only", 3'b011);
    set_in(8'b1011_0001);
    edges(4);
    set_in(8'b0000_0001);
    edges(1);
    check("R6 no-AC over dc", 3'b101);
    set_in(8'b0000_0011);
    edges(1);
    set_in(8'b0000_0001);
    check("R6 multi head held", 3'b101);
    set_in(8'b0001_0001);
    edges(4);
    set_in(8'b0000_0001);
    edges(1);
    check("R6 top priority", 3'b100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule